// File: doc/BRIEF.md
# Prioritized Supply Selection Controller

This block chooses which of three input power rails feeds a shared load. It works from comparator results that have already been digitized. For each rail it receives an in-window flag, which combines the undervoltage and overvoltage checks, and a reverse-voltage-OK flag. A rail counts as qualified only after its in-window flag has stayed true for a programmable number of clock ticks without a break. The controller then connects the qualified rail with the highest priority. Rail 1 has the highest priority and rail 3 the lowest.

Moving from one rail to another is always break-before-make. The old gate turns off, all gates stay off for at least one clock, and only then may the new gate turn on. The new gate also waits until that rail's reverse-voltage-OK flag is true.

Two shared controls act on all rails. An enable input forces every gate off but keeps the qualification timers running. An active-low shutdown input forces every gate off and also clears the timers.

A soft-start flag tells the gate drivers to use the slow ramp. The flag is armed by reset, by shutdown, and by a low-output indication. It is cleared when any gate turns off, or after a programmable number of ticks during which a gate is on in soft-start.

Top module: `supsel_ctrl`

## Requirements
- R1: `valid_n[i]` goes low only after `in_win[i]` has been sampled high on QUAL_TICKS consecutive rising clock edges. It is still high after QUAL_TICKS-1 such edges. Bit 0 is rail 1, bit 1 is rail 2 and bit 2 is rail 3.
- R2: An edge that samples `in_win[i]` low drives `valid_n[i]` high after that edge. Qualification then starts again from zero.
- R3: A gate that is on always belongs to the lowest-index rail that was qualified on the previous edge. When a higher-priority rail qualifies, the controller moves to it.
- R4: An edge that samples `en` low turns all of `gate_on` off after that edge. The qualification state seen on `valid_n` is not disturbed. When `en` returns high, the highest-priority qualified rail is connected again without a new qualification interval.
- R5: An edge that samples `shdn_n` low turns all gates off and sets every `valid_n` bit high after that edge. Once `shdn_n` is released, a full QUAL_TICKS interval is needed again.
- R6: At most one bit of `gate_on` is ever high. A change from one rail to another always passes through at least one cycle in which `gate_on` is 0.
- R7: A gate turns on only in the cycle after an edge that sampled that rail's `rev_ok` high. While `rev_ok` is low, the gate stays off.
- R8: When no rail is qualified, `gate_on` stays 0.
- R9: `soft_start` is 1 after reset. It is also 1 after any edge that samples `shdn_n` low or `out_low` high.
- R10: `soft_start` clears on the edge after a gate has turned off.
- R11: During soft-start with a gate on, `soft_start` clears after SS_TICKS edges counted from the first edge that sees the gate on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_win | input | 3 | Per-rail in-window comparator result |
| rev_ok | input | 3 | Per-rail reverse-voltage-OK flag (output far enough below the rail) |
| en | input | 1 | Enable; low forces all gates off while timers keep running |
| shdn_n | input | 1 | Active-low shutdown; gates off and timers cleared |
| out_low | input | 1 | Output-below-threshold flag; arms soft-start |
| gate_on | output | 3 | Per-rail gate command, one-hot or zero |
| valid_n | output | 3 | Per-rail qualified indicator, active low |
| soft_start | output | 1 | Soft-start ramp mode flag |

## Verification
The assertions assume that every input is already synchronous to `clk` and changes at most once per cycle. They also assume that `rev_ok` matters only for the rail that is being connected. The bench meets these assumptions by changing inputs only at falling clock edges. It holds each level for whole cycles, so every comparator flag the design sees is a clean, glitch-free sample. The priority and break-before-make properties then depend only on the sampled history of `in_win`, `en` and `shdn_n`. The bench walks through that history with promotions, dropouts, enable gaps and shutdowns.

// File: rtl/supsel_pkg.sv
package supsel_pkg;

    localparam int NCH = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_REV,
        ST_ON,
        ST_BREAK
    } conn_state_e;

    typedef struct packed {
        conn_state_e     state;
        logic [NCH-1:0]  sel;
    } conn_t;

    // One-hot of the lowest set bit (bit 0 = highest priority rail)
    function automatic logic [NCH-1:0] pick_highest(input logic [NCH-1:0] v);
        logic [NCH-1:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (v[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/supsel_qual_timer.sv
module supsel_qual_timer #(
    parameter int unsigned QUAL_TICKS = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic in_win,
    input  logic shdn_n,
    output logic qualified
);
    localparam int CW = $clog2(QUAL_TICKS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !shdn_n || !in_win) begin
            cnt <= '0;
        end else if (cnt != CW'(QUAL_TICKS)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qualified = (cnt == CW'(QUAL_TICKS));

    AST_SHDN_DEQUALIFIES: assert property (@(posedge clk) disable iff (rst)
        !shdn_n |=> !qualified);                                   // R5
    AST_DROP_DEQUALIFIES: assert property (@(posedge clk) disable iff (rst)
        !in_win |=> !qualified);                                   // R2
    AST_QUAL_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $rose(qualified) |-> $past(in_win));                       // R1

endmodule

// File: rtl/supsel_arbiter.sv
module supsel_arbiter
    import supsel_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] qualified,
    input  logic [NCH-1:0] rev_ok,
    input  logic           en,
    input  logic           shdn_n,
    output logic [NCH-1:0] gate
);
    conn_t          cur, nxt;
    logic [NCH-1:0] target;

    assign target = (en && shdn_n) ? pick_highest(qualified) : '0;

    always_comb begin
        nxt = cur;
        unique case (cur.state)
            ST_IDLE: begin
                if (|target) begin
                    nxt.state = ST_WAIT_REV;
                    nxt.sel   = target;
                end
            end
            ST_WAIT_REV: begin
                if (target != cur.sel) begin
                    nxt.state = ST_IDLE;
                end else if (|(rev_ok & cur.sel)) begin
                    nxt.state = ST_ON;
                end
            end
            ST_ON: begin
                if (target != cur.sel) begin
                    nxt.state = ST_BREAK;
                end
            end
            default: begin
                nxt.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.state <= ST_IDLE;
            cur.sel   <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign gate = (cur.state == ST_ON) ? cur.sel : '0;

    AST_GATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate));                                            // R6
    AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (rst)
        ((|gate) && (|$past(gate))) |-> (gate == $past(gate)));     // R6
    AST_REV_BEFORE_ON: assert property (@(posedge clk) disable iff (rst)
        (|(gate & ~$past(gate))) |-> (|(gate & $past(rev_ok))));    // R7
    AST_EN_DROPS: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gate == '0));                                      // R4
    AST_SHDN_DROPS: assert property (@(posedge clk) disable iff (rst)
        !shdn_n |=> (gate == '0));                                  // R5
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        (qualified == '0) |=> (gate == '0));                        // R8
    AST_GATE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (|gate) |-> (|(gate & $past(qualified))));                  // R3
    AST_GATE_TOP_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (|gate) |-> (($past(qualified) & (gate - 1'b1)) == '0));    // R3

endmodule

// File: rtl/supsel_softstart.sv
module supsel_softstart
    import supsel_pkg::*;
#(
    parameter int unsigned SS_TICKS = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shdn_n,
    input  logic           out_low,
    input  logic [NCH-1:0] gate,
    output logic           soft_start
);
    localparam int CW = $clog2(SS_TICKS + 1);

    logic [CW-1:0]  cnt;
    logic [NCH-1:0] gate_prev;
    logic           arm, fell, run;

    assign arm  = !shdn_n || out_low;
    assign fell = |(gate_prev & ~gate);
    assign run  = soft_start && (|gate);

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_start <= 1'b1;
            cnt        <= '0;
            gate_prev  <= '0;
        end else begin
            gate_prev <= gate;
            if (arm) begin
                soft_start <= 1'b1;
                cnt        <= '0;
            end else if (fell) begin
                soft_start <= 1'b0;
                cnt        <= '0;
            end else if (run) begin
                if (cnt == CW'(SS_TICKS - 1)) begin
                    soft_start <= 1'b0;
                    cnt        <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    AST_SS_ARM: assert property (@(posedge clk) disable iff (rst)
        (!shdn_n || out_low) |=> soft_start);                       // R9
    AST_SS_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
        (shdn_n && !out_low && (|($past(gate) & ~gate))) |=> !soft_start); // R10
    AST_SS_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!soft_start && shdn_n && !out_low) |=> !soft_start);       // R11

endmodule

// File: rtl/supsel_ctrl.sv
module supsel_ctrl
    import supsel_pkg::*;
#(
    parameter int unsigned QUAL_TICKS = 256,
    parameter int unsigned SS_TICKS   = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] in_win,
    input  logic [2:0] rev_ok,
    input  logic       en,
    input  logic       shdn_n,
    input  logic       out_low,
    output logic [2:0] gate_on,
    output logic [2:0] valid_n,
    output logic       soft_start
);
    logic [NCH-1:0] qualified;

    for (genvar g = 0; g < NCH; g++) begin : g_rail
        supsel_qual_timer #(
            .QUAL_TICKS (QUAL_TICKS)
        ) i_timer (
            .clk       (clk),
            .rst       (rst),
            .in_win    (in_win[g]),
            .shdn_n    (shdn_n),
            .qualified (qualified[g])
        );
    end

    assign valid_n = ~qualified;

    supsel_arbiter i_arb (
        .clk       (clk),
        .rst       (rst),
        .qualified (qualified),
        .rev_ok    (rev_ok),
        .en        (en),
        .shdn_n    (shdn_n),
        .gate      (gate_on)
    );

    supsel_softstart #(
        .SS_TICKS (SS_TICKS)
    ) i_ss (
        .clk        (clk),
        .rst        (rst),
        .shdn_n     (shdn_n),
        .out_low    (out_low),
        .gate       (gate_on),
        .soft_start (soft_start)
    );

    AST_VALID_GATE_AGREE: assert property (@(posedge clk) disable iff (rst)
        (|gate_on) |-> (|(gate_on & ~$past(valid_n))));              // R3

endmodule

// File: tb/test_supsel_ctrl.sv
module test_supsel_ctrl;

    localparam int QT = 8;
    localparam int ST = 6;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] in_win, rev_ok;
    logic       en, shdn_n, out_low;
    logic [2:0] gate_on, valid_n;
    logic       soft_start;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    supsel_ctrl #(.QUAL_TICKS(QT), .SS_TICKS(ST)) i_supsel_ctrl (
        .clk(clk), .rst(rst), .in_win(in_win), .rev_ok(rev_ok), .en(en),
        .shdn_n(shdn_n), .out_low(out_low), .gate_on(gate_on),
        .valid_n(valid_n), .soft_start(soft_start)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: act=%0d exp<%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wait_gate(input logic [2:0] exp, input int lim, input string req);
        logic found = 1'b0;
        for (int k = 0; k < lim && !found; k++) begin
            step(1);
            if (gate_on == exp) found = 1'b1;
        end
        chk(req, {5'd0, gate_on}, {5'd0, exp});
    endtask

    task automatic do_reset();
        rst = 1'b1; in_win = 3'b000; rev_ok = 3'b111;
        en = 1'b1; shdn_n = 1'b1; out_low = 1'b0;
        step(3);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R9 reset gates", {5'd0, gate_on}, 8'h0);
        chk("R9 reset valid_n", {5'd0, valid_n}, 8'h7);
        chk("R9 reset soft_start", {7'd0, soft_start}, 8'h1);
    endtask

    // R1 exact qualification, R7 reverse hold-off
    task automatic t_qualify_rev();
        rev_ok = 3'b101;
        in_win = 3'b010;
        step(QT - 1);
        chk("R1 not yet valid", {7'd0, valid_n[1]}, 8'h1);
        step(1);
        chk("R1 valid after QT", {7'd0, valid_n[1]}, 8'h0);
        step(4);
        chk("R7 held off without rev_ok", {5'd0, gate_on}, 8'h0);
        rev_ok = 3'b111;
        step(1);
        chk("R7 gate on after rev_ok", {5'd0, gate_on}, 8'h2);
    endtask

    // R3 promotion to higher priority, R6 break-before-make
    task automatic t_promote();
        logic [2:0] prev;
        logic gap = 1'b0;
        logic bad = 1'b0;
        in_win = 3'b011;
        step(QT);
        chk("R1 rail1 valid", {5'd0, valid_n}, 8'h4);
        prev = gate_on;
        for (int k = 0; k < 10; k++) begin
            step(1);
            if ($countones(gate_on) > 1) bad = 1'b1;
            if (prev != 3'b000 && gate_on != 3'b000 && gate_on != prev) bad = 1'b1;
            if (gate_on == 3'b000) gap = 1'b1;
            prev = gate_on;
        end
        chk("R6 no overlap or direct swap", {7'd0, bad}, 8'h0);
        chk("R6 off gap seen", {7'd0, gap}, 8'h1);
        chk("R3 highest priority connected", {5'd0, gate_on}, 8'h1);
    endtask

    // R2 dropout, fallback, restart from zero
    task automatic t_dropout();
        in_win = 3'b010;
        step(1);
        chk("R2 valid_n high after drop", {7'd0, valid_n[0]}, 8'h1);
        wait_gate(3'b010, 8, "R2 fallback to rail2");
        in_win = 3'b011;
        step(QT - 2);
        in_win = 3'b010;
        step(1);
        in_win = 3'b011;
        step(QT - 1);
        chk("R2 restart from zero", {7'd0, valid_n[0]}, 8'h1);
        step(1);
        chk("R2 requalified", {7'd0, valid_n[0]}, 8'h0);
        wait_gate(3'b001, 8, "R3 back to rail1");
    endtask

    task automatic t_enable();
        en = 1'b0;
        step(1);
        chk("R4 gates off", {5'd0, gate_on}, 8'h0);
        step(3);
        chk("R4 timers kept", {5'd0, valid_n}, 8'h4);
        en = 1'b1;
        wait_gate(3'b001, 5, "R4 reconnect");
    endtask

    task automatic t_shutdown();
        shdn_n = 1'b0;
        step(1);
        chk("R5 gates off", {5'd0, gate_on}, 8'h0);
        chk("R5 timers cleared", {5'd0, valid_n}, 8'h7);
        chk("R9 shutdown arms", {7'd0, soft_start}, 8'h1);
        step(2);
        shdn_n = 1'b1;
        step(QT - 1);
        chk("R5 fresh interval", {5'd0, valid_n}, 8'h7);
        step(1);
        chk("R5 requalified", {5'd0, valid_n}, 8'h4);
    endtask

    task automatic t_idle();
        logic bad = 1'b0;
        in_win = 3'b000;
        step(2);
        chk("R8 none valid", {5'd0, valid_n}, 8'h7);
        for (int k = 0; k < 8; k++) begin
            step(1);
            if (gate_on != 3'b000) bad = 1'b1;
        end
        chk("R8 gates stay off", {7'd0, bad}, 8'h0);
    endtask

    task automatic t_softstart();
        do_reset();
        in_win = 3'b100;
        wait_gate(3'b100, QT + 6, "R3 rail3 alone");
        chk("R9 armed from reset", {7'd0, soft_start}, 8'h1);
        en = 1'b0;
        step(1);
        chk("R4 off", {5'd0, gate_on}, 8'h0);
        step(1);
        chk("R10 cleared on gate off", {7'd0, soft_start}, 8'h0);
        out_low = 1'b1;
        step(1);
        chk("R9 out_low arms", {7'd0, soft_start}, 8'h1);
        out_low = 1'b0;
        en = 1'b1;
        wait_gate(3'b100, 6, "R4 reconnect rail3");
        step(ST - 1);
        chk("R11 still soft", {7'd0, soft_start}, 8'h1);
        step(1);
        chk("R11 timed out", {7'd0, soft_start}, 8'h0);
    endtask

    initial begin
        t_reset();
        t_qualify_rev();
        t_promote();
        t_dropout();
        t_enable();
        t_shutdown();
        t_idle();
        t_softstart();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule